// File: doc/BRIEF.md
# Cascaded 32-bit Timestamp Capture Unit

This block joins two half-width up-counters into one wide timestamp counter and latches that timestamp when an external capture strobe arrives. The low half advances on every clock cycle in which the count enable is high. Its wrap from all-ones to zero is registered and used as the step for the high half, so the high half moves one clock after the wrap.

To keep a captured word coherent, the low half is sampled on the cycle of the strobe. The high half is sampled one clock later, when it has caught up. Both halves are then written together into a two-deep store, which has a capture register and a buffer behind it. One control state machine governs the store, and its states are `ST_EMPTY`, `ST_ONE` and `ST_TWO`. Its transitions are:
- `FIRST`: `ST_EMPTY` to `ST_ONE` on a capture.
- `SPILL`: `ST_ONE` to `ST_TWO` on a capture.
- `SWAP`: `ST_ONE` to `ST_ONE` on a capture together with a read.
- `DRAIN`: `ST_ONE` to `ST_EMPTY` on a read.
- `SHIFT`: `ST_TWO` to `ST_TWO` on a capture together with a read.
- `POP`: `ST_TWO` to `ST_ONE` on a read.
- `REJECT`: `ST_TWO` to `ST_TWO` on a capture. The new word is dropped and the sticky error flag is raised.

Software takes the word on `rd_data` and then pulses `rd_stb` to consume it.

Top module: `cascade_capture32`

## Requirements
- R1: While `rst` is high, and after it is released with `tick_en` low, both counter halves read 0, `cap_flag`, `buf_valid` and `err_flag` are 0, and `rd_data` is 0.
- R2: `count_lo` increases by exactly one after each clock edge at which `tick_en` is 1, and holds its value after an edge at which `tick_en` is 0.
- R3: After the edge where `count_lo` wraps from all-ones to zero, `count_hi` keeps its old value for one more clock. It then increases by one at the following edge.
- R4: A capture strobe sampled at edge t stores the number of enabled ticks seen before edge t (modulo 2^(2·HALF_W)). The word is arranged as {high half, low half} on `rd_data`. This holds when the strobe falls on the all-ones low value, and also when it falls on the zero low value that comes right after the wrap.
- R5: A strobe sampled at edge t is committed at edge t+1. With the store empty, that word goes to the capture register, `cap_flag` rises, and `cap_irq` equals `cap_flag` AND `cap_ie`.
- R6: A capture committed while only the register is full goes to the buffer, and `buf_valid` rises. `rd_data` keeps the older word.
- R7: A read while the buffer is full moves the buffered word to `rd_data` and clears `buf_valid`, and `cap_flag` stays 1. A read with only the register full clears `cap_flag`.
- R8: A capture committed while register and buffer are both full is rejected, and `err_flag` is set. The register and the buffer keep their words.
- R9: `err_flag` stays set until an `err_clr` pulse, and `err_irq` equals `err_flag` AND `err_ie`.
- R10: A read in the same cycle as a commit consumes the current register word. In `ST_ONE` the new word lands in the register and `buf_valid` stays 0. In `ST_TWO` the buffered word moves to the register, the new word fills the buffer, and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable for the low half |
| cap_evt | input | 1 | Capture strobe, one cycle per event |
| rd_stb | input | 1 | Consume the word on `rd_data` |
| err_clr | input | 1 | Clear the overflow error flag |
| cap_ie | input | 1 | Enable for the capture interrupt |
| err_ie | input | 1 | Enable for the error interrupt |
| count_lo | output | HALF_W | Low counter half |
| count_hi | output | HALF_W | High counter half |
| rd_data | output | 2*HALF_W | Capture register, {high, low} |
| cap_flag | output | 1 | Capture register holds a word |
| buf_valid | output | 1 | Buffer holds a word |
| err_flag | output | 1 | Sticky buffer-overflow flag |
| cap_irq | output | 1 | Gated capture interrupt |
| err_irq | output | 1 | Gated error interrupt |

## Verification
Each result in this block has a fixed latency. A counter step shows one edge after the enabling edge, and the high-half step shows two edges after the wrapping edge. A capture shows in the store flags and `rd_data` two edges after the strobe is driven, and a read or error clear shows one edge after its pulse. The bench drives every input on the falling edge and samples after exactly that many rising edges. It reads `rd_data` combinationally in the same half-cycle as the read pulse, before the edge that consumes the word. Expected timestamps come from a tick tally kept by the bench, captured at the moment the strobe is driven.

// File: rtl/cap32_pkg.sv
package cap32_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_ONE   = 2'd1,
        ST_TWO   = 2'd2
    } slot_state_e;

    typedef enum logic [2:0] {
        ACT_NONE       = 3'd0,
        ACT_LOAD_REG   = 3'd1,
        ACT_LOAD_BUF   = 3'd2,
        ACT_SHIFT_LOAD = 3'd3,
        ACT_POP        = 3'd4
    } store_act_e;

endpackage

// File: rtl/cap32_counter_half.sv
module cap32_counter_half #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] value
);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (step) begin
            value <= value + 1'b1;
        end
    end

endmodule

// File: rtl/cap32_half_store.sv
module cap32_half_store
    import cap32_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  store_act_e   act,
    input  logic [W-1:0] din,
    output logic [W-1:0] reg_q,
    output logic [W-1:0] buf_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
            buf_q <= '0;
        end else begin
            case (act)
                ACT_LOAD_REG: begin
                    reg_q <= din;
                end
                ACT_LOAD_BUF: begin
                    buf_q <= din;
                end
                ACT_SHIFT_LOAD: begin
                    reg_q <= buf_q;
                    buf_q <= din;
                end
                ACT_POP: begin
                    reg_q <= buf_q;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/cap32_slot_fsm.sv
module cap32_slot_fsm
    import cap32_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       commit,
    input  logic       rd_stb,
    input  logic       err_clr,
    output store_act_e act,
    output logic       cap_flag,
    output logic       buf_valid,
    output logic       err_flag
);

    slot_state_e state_q;
    slot_state_e state_d;
    logic        reject;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions and store commands
    always_comb begin
        state_d = state_q;
        act     = ACT_NONE;
        reject  = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (commit) begin            // FIRST
                    act     = ACT_LOAD_REG;
                    state_d = ST_ONE;
                end
            end
            ST_ONE: begin
                if (commit && rd_stb) begin  // SWAP
                    act     = ACT_LOAD_REG;
                    state_d = ST_ONE;
                end else if (commit) begin   // SPILL
                    act     = ACT_LOAD_BUF;
                    state_d = ST_TWO;
                end else if (rd_stb) begin   // DRAIN
                    state_d = ST_EMPTY;
                end
            end
            ST_TWO: begin
                if (commit && rd_stb) begin  // SHIFT
                    act     = ACT_SHIFT_LOAD;
                    state_d = ST_TWO;
                end else if (commit) begin   // REJECT
                    reject  = 1'b1;
                end else if (rd_stb) begin   // POP
                    act     = ACT_POP;
                    state_d = ST_ONE;
                end
            end
            default: begin
                state_d = ST_EMPTY;
            end
        endcase
    end

    // flag outputs
    always_comb begin
        cap_flag  = (state_q != ST_EMPTY);
        buf_valid = (state_q == ST_TWO);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag <= 1'b0;
        end else if (reject) begin
            err_flag <= 1'b1;
        end else if (err_clr) begin
            err_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/cascade_capture32.sv
module cascade_capture32
    import cap32_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_en,
    input  logic                  cap_evt,
    input  logic                  rd_stb,
    input  logic                  err_clr,
    input  logic                  cap_ie,
    input  logic                  err_ie,
    output logic [HALF_W-1:0]     count_lo,
    output logic [HALF_W-1:0]     count_hi,
    output logic [2*HALF_W-1:0]   rd_data,
    output logic                  cap_flag,
    output logic                  buf_valid,
    output logic                  err_flag,
    output logic                  cap_irq,
    output logic                  err_irq
);

    localparam int FULL_W  = 2 * HALF_W;
    localparam int N_HALVES = 2;

    logic              lo_wrap;
    logic              hi_step_q;
    logic              evt_q;
    logic [HALF_W-1:0] lo_stage_q;
    logic [FULL_W-1:0] commit_word;
    logic [FULL_W-1:0] buf_word;
    store_act_e        act;

    assign lo_wrap = tick_en & (&count_lo);

    cap32_counter_half #(.W(HALF_W)) u_lo (
        .clk   (clk),
        .rst   (rst),
        .step  (tick_en),
        .value (count_lo)
    );

    cap32_counter_half #(.W(HALF_W)) u_hi (
        .clk   (clk),
        .rst   (rst),
        .step  (hi_step_q),
        .value (count_hi)
    );

    // low half sampled on the strobe; high half one clock later
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_step_q  <= 1'b0;
            evt_q      <= 1'b0;
            lo_stage_q <= '0;
        end else begin
            hi_step_q <= lo_wrap;
            evt_q     <= cap_evt;
            if (cap_evt) begin
                lo_stage_q <= count_lo;
            end
        end
    end

    assign commit_word = {count_hi, lo_stage_q};

    cap32_slot_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .commit    (evt_q),
        .rd_stb    (rd_stb),
        .err_clr   (err_clr),
        .act       (act),
        .cap_flag  (cap_flag),
        .buf_valid (buf_valid),
        .err_flag  (err_flag)
    );

    for (genvar g = 0; g < N_HALVES; g++) begin : g_half
        cap32_half_store #(.W(HALF_W)) u_store (
            .clk   (clk),
            .rst   (rst),
            .act   (act),
            .din   (commit_word[g*HALF_W +: HALF_W]),
            .reg_q (rd_data[g*HALF_W +: HALF_W]),
            .buf_q (buf_word[g*HALF_W +: HALF_W])
        );
    end

    assign cap_irq = cap_flag & cap_ie;
    assign err_irq = err_flag & err_ie;

endmodule

// File: rtl/cap32_checker.sv
module cap32_checker #(
    parameter int HALF_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              commit,
    input logic              rd_stb,
    input logic              err_clr,
    input logic [HALF_W-1:0] count_lo,
    input logic [HALF_W-1:0] count_hi,
    input logic              cap_flag,
    input logic              buf_valid,
    input logic              err_flag
);

    assert_lo_step_R2: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> count_lo == $past(count_lo) + 1'b1);

    assert_lo_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(count_lo));

    assert_hi_lag_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_en && (&count_lo)) |=> $stable(count_hi));

    assert_hi_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_en && (&count_lo)) |=> ##1 (count_hi == $past(count_hi, 2) + 1'b1));

    assert_first_load_R5: assert property (@(posedge clk) disable iff (rst)
        (commit && !cap_flag) |=> (cap_flag && !buf_valid));

    assert_spill_R6: assert property (@(posedge clk) disable iff (rst)
        (commit && cap_flag && !buf_valid && !rd_stb) |=> buf_valid);

    assert_pop_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && buf_valid && !commit) |=> (cap_flag && !buf_valid));

    assert_drain_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && cap_flag && !buf_valid && !commit) |=> !cap_flag);

    assert_reject_R8: assert property (@(posedge clk) disable iff (rst)
        (commit && buf_valid && !rd_stb) |=> (err_flag && buf_valid));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !err_clr) |=> err_flag);

    assert_shift_R10: assert property (@(posedge clk) disable iff (rst)
        (commit && rd_stb && buf_valid && !err_flag) |=> (buf_valid && !err_flag));

endmodule

bind cascade_capture32 cap32_checker #(.HALF_W(HALF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .commit    (evt_q),
    .rd_stb    (rd_stb),
    .err_clr   (err_clr),
    .count_lo  (count_lo),
    .count_hi  (count_hi),
    .cap_flag  (cap_flag),
    .buf_valid (buf_valid),
    .err_flag  (err_flag)
);

// File: tb/cascade_capture32_test.sv
`timescale 1ns/1ps
module cascade_capture32_test;

    localparam int W  = 8;
    localparam int FW = 2 * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_en = 1'b0;
    logic          cap_evt = 1'b0;
    logic          rd_stb = 1'b0;
    logic          err_clr = 1'b0;
    logic          cap_ie = 1'b0;
    logic          err_ie = 1'b0;
    logic [W-1:0]  count_lo;
    logic [W-1:0]  count_hi;
    logic [FW-1:0] rd_data;
    logic          cap_flag;
    logic          buf_valid;
    logic          err_flag;
    logic          cap_irq;
    logic          err_irq;

    int            n_chk = 0;
    int            n_bad = 0;
    bit            finished = 1'b0;
    logic [FW-1:0] tally = '0;

    always #2 clk = ~clk;

    cascade_capture32 #(.HALF_W(W)) uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .cap_evt(cap_evt),
        .rd_stb(rd_stb), .err_clr(err_clr), .cap_ie(cap_ie), .err_ie(err_ie),
        .count_lo(count_lo), .count_hi(count_hi), .rd_data(rd_data),
        .cap_flag(cap_flag), .buf_valid(buf_valid), .err_flag(err_flag),
        .cap_irq(cap_irq), .err_irq(err_irq)
    );

    // enabled-tick tally: value before the next rising edge
    always @(posedge clk) begin
        if (rst) tally <= '0;
        else if (tick_en) tally <= tally + 1'b1;
    end

    task automatic chk(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // strobe at one falling edge; result visible two falling edges later
    task automatic fire(output logic [FW-1:0] exp);
        @(negedge clk);
        cap_evt = 1'b1;
        exp = tally;
        @(negedge clk);
        cap_evt = 1'b0;
        @(negedge clk);
    endtask

    // present data before the consuming edge, then pulse one cycle
    task automatic take(input string req, input logic [FW-1:0] exp);
        @(negedge clk);
        chk(req, rd_data, exp);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 lo", FW'(count_lo), '0);
        chk("R1 hi", FW'(count_hi), '0);
        chk("R1 flags", FW'({cap_flag, buf_valid, err_flag}), '0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 lo after release", FW'(count_lo), '0);
        chk("R1 data", rd_data, '0);
    endtask

    task automatic t_count();
        logic [W-1:0] held;
        tick_en = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 count", FW'(count_lo), FW'(5));
        tick_en = 1'b0;
        @(negedge clk);
        held = count_lo;
        repeat (3) @(negedge clk);
        chk("R2 hold", FW'(count_lo), FW'(held));
        tick_en = 1'b1;
        @(negedge clk);
        chk("R2 resume", FW'(count_lo), FW'(held + 1'b1));
    endtask

    task automatic t_store();
        logic [FW-1:0] a, b, c;
        cap_ie = 1'b1;
        fire(a);
        chk("R5 flag", FW'(cap_flag), FW'(1));
        chk("R5 irq", FW'(cap_irq), FW'(1));
        chk("R5 no buf", FW'(buf_valid), '0);
        chk("R4 value", rd_data, a);
        fire(b);
        chk("R6 buf", FW'(buf_valid), FW'(1));
        chk("R6 keeps older", rd_data, a);
        fire(c);
        chk("R8 err", FW'(err_flag), FW'(1));
        chk("R9 irq gated", FW'(err_irq), '0);
        err_ie = 1'b1;
        #0.5;
        chk("R9 irq", FW'(err_irq), FW'(1));
        take("R8 reg kept", a);
        chk("R7 pop buf", FW'(buf_valid), '0);
        chk("R7 pop flag", FW'(cap_flag), FW'(1));
        chk("R9 sticky", FW'(err_flag), FW'(1));
        take("R8 buf kept", b);
        chk("R7 drain", FW'(cap_flag), '0);
        chk("R5 irq off", FW'(cap_irq), '0);
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk("R9 clear", FW'(err_flag), '0);
    endtask

    task automatic t_wrap();
        logic [FW-1:0] ea, eb;
        logic [W-1:0]  hold_hi;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (tally[W-1:0] == {W{1'b1}}) break;
        end
        hold_hi = count_hi;
        cap_evt = 1'b1;
        ea = tally;
        @(negedge clk);
        chk("R3 lo wrapped", FW'(count_lo), '0);
        chk("R3 hi lags", FW'(count_hi), FW'(hold_hi));
        eb = tally;
        @(negedge clk);
        cap_evt = 1'b0;
        chk("R3 hi step", FW'(count_hi), FW'(hold_hi + 1'b1));
        @(negedge clk);
        chk("R6 two held", FW'(buf_valid), FW'(1));
        take("R4 all-ones low", ea);
        take("R4 zero low", eb);
        chk("R4 hi of zero-low word", FW'(eb[FW-1:W]), FW'(hold_hi + 1'b1));
    endtask

    task automatic t_same_cycle();
        logic [FW-1:0] c, d, e, f;
        fire(c);
        @(negedge clk);
        cap_evt = 1'b1;
        d = tally;
        @(negedge clk);
        cap_evt = 1'b0;
        chk("R10 one old word", rd_data, c);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        chk("R10 one flag", FW'({cap_flag, buf_valid}), FW'(2'b10));
        chk("R10 one new", rd_data, d);
        fire(e);
        chk("R10 two", FW'(buf_valid), FW'(1));
        @(negedge clk);
        cap_evt = 1'b1;
        f = tally;
        @(negedge clk);
        cap_evt = 1'b0;
        chk("R10 two old word", rd_data, d);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        chk("R10 two no err", FW'(err_flag), '0);
        chk("R10 two buf", FW'(buf_valid), FW'(1));
        take("R10 moved", e);
        take("R10 newest", f);
        chk("R10 empty", FW'(cap_flag), '0);
    endtask

    initial begin
        t_reset();
        t_count();
        t_store();
        t_wrap();
        t_same_cycle();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule